// File: doc/BRIEF.md
# Single-Step and Resume-Flag Sequencer

This block sits at the retire boundary of a processor core and decides, one instruction at a time, which debug event the instruction raises. It can raise an instruction-breakpoint fault before the instruction runs. After the instruction completes it can raise a single-step trap, a task-switch trap, or both. It owns the trap flag (TF) and the resume flag (RF). It clears TF on every entry to a handler. It sets RF before it delivers an ordinary fault, and it uses RF to stop the same breakpoint from firing again when the instruction is restarted.

Each cycle carries at most one instruction event. The event says whether the instruction faulted, whether a breakpoint match unit reported a hit, whether the instruction writes TF, loads the stack segment or switches task, and whether an external interrupt is pending. When no instruction is present, a return from a handler can reload both flags from a saved image. Every output is registered, so its value appears in the cycle after the event.

Top module: `dbg_step_seq`

## Requirements
- R1: A completing instruction raises `o_dbg_trap` and `o_st_step` in the next cycle if TF was 1 before it ran. TF here means the value before the instruction's own write.
- R2: An instruction that writes TF from 0 to 1 raises no trap. An instruction that writes TF from 1 to 0 does raise one.
- R3: TF reads 0 after any handler entry. Handler entries are a breakpoint fault, an ordinary fault, a raised trap, and an interrupt pending at completion. Otherwise a completing instruction leaves TF at its written value, or keeps the old value when it does not write TF.
- R4: When a trap is raised and `i_irq_req` is high for the same instruction, `o_irq_first` pulses together with `o_dbg_trap`. This tells the core to service the interrupt before the first instruction of the debug handler, and TF is cleared.
- R5: `i_bkpt_hit` raises `o_bkpt_fault` only when RF is 0. The breakpoint fault takes priority over an ordinary fault and over completion: the instruction raises no trap, RF keeps its value and TF is cleared.
- R6: A breakpoint hit is ignored on the instruction that follows a completed stack-segment load (`i_ss_load`). Any instruction event closes this window.
- R7: An ordinary fault (`i_insn_fault`) sets RF to 1. It also drops any single-step or task trap, because the instruction did not complete.
- R8: RF is cleared by every completing instruction except one that switches task (`i_task_sw`), which leaves RF unchanged.
- R9: A completing task switch whose target has its trap bit set raises `o_dbg_trap` and `o_st_task` in the next cycle.
- R10: A handler return (`i_restore` with no instruction present) loads TF and RF from the image. `i_restore` is ignored in a cycle with an instruction. RF changes by no other means than R5, R7 and R8.
- R11: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| i_insn_valid | input | 1 | An instruction event is present this cycle |
| i_insn_fault | input | 1 | The instruction raised an ordinary fault |
| i_bkpt_hit | input | 1 | The breakpoint match unit hit on this instruction |
| i_tf_wr | input | 1 | The instruction writes TF |
| i_tf_wval | input | 1 | Value written to TF |
| i_ss_load | input | 1 | The instruction loads the stack segment |
| i_task_sw | input | 1 | The instruction performs a task switch |
| i_task_trap_bit | input | 1 | The target task has its trap bit set |
| i_irq_req | input | 1 | An external interrupt is pending |
| i_restore | input | 1 | A handler return restores the flags image |
| i_restore_tf | input | 1 | TF in the restored image |
| i_restore_rf | input | 1 | RF in the restored image |
| o_bkpt_fault | output | 1 | Instruction-breakpoint fault request |
| o_dbg_trap | output | 1 | Debug trap request (single-step or task switch) |
| o_irq_first | output | 1 | Service the interrupt before the debug handler |
| o_st_step | output | 1 | Status pulse: single-step caused the trap |
| o_st_task | output | 1 | Status pulse: task switch caused the trap |
| o_tf | output | 1 | Current trap flag |
| o_rf | output | 1 | Current resume flag |

## Verification
The bench walks through all 4096 combinations of the twelve event inputs, in a scrambled order. Because the flags carry over from one cycle to the next, each combination meets many different starting values of TF, RF and the stack-segment window. This separates the four event classes: breakpoint hits with RF clear, breakpoint hits with RF set, and hits inside the window are told apart from one another and from ordinary faults and completions. Short directed sequences then cover the cases a sweep reaches only by chance: TF being set and then cleared (R2), a stack-segment load followed by a breakpoint (R6), and a fault that restarts and then runs past the breakpoint because RF is set (R5, R7).

// File: rtl/dbg_step_pkg.sv
package dbg_step_pkg;
  typedef enum logic [1:0] {
    EV_NONE  = 2'd0,
    EV_BKPT  = 2'd1,
    EV_FAULT = 2'd2,
    EV_DONE  = 2'd3
  } ev_e;

  // Trap flag after the event: any handler entry clears it.
  function automatic logic tf_after(ev_e ev, logic tf_q, logic wr, logic wv,
                                    logic enter, logic rst_ld, logic rst_tf);
    logic r;
    case (ev)
      EV_NONE:  r = rst_ld ? rst_tf : tf_q;
      EV_DONE:  r = enter ? 1'b0 : (wr ? wv : tf_q);
      default:  r = 1'b0;
    endcase
    return r;
  endfunction

  // Resume flag after the event.
  function automatic logic rf_after(ev_e ev, logic rf_q, logic task_sw,
                                    logic rst_ld, logic rst_rf);
    logic r;
    case (ev)
      EV_NONE:  r = rst_ld ? rst_rf : rf_q;
      EV_FAULT: r = 1'b1;
      EV_DONE:  r = task_sw ? rf_q : 1'b0;
      default:  r = rf_q;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/dbg_bkpt_gate.sv
module dbg_bkpt_gate
  import dbg_step_pkg::*;
(
  input  logic insn_valid,
  input  logic insn_fault,
  input  logic bkpt_hit,
  input  logic rf_q,
  input  logic shadow_q,
  output logic bkpt_take,
  output ev_e  ev
);
  always_comb begin
    bkpt_take = insn_valid && bkpt_hit && !rf_q && !shadow_q;
    if (!insn_valid)     ev = EV_NONE;
    else if (bkpt_take)  ev = EV_BKPT;
    else if (insn_fault) ev = EV_FAULT;
    else                 ev = EV_DONE;
  end
endmodule

// File: rtl/dbg_trap_eval.sv
module dbg_trap_eval
  import dbg_step_pkg::*;
(
  input  ev_e  ev,
  input  logic tf_q,
  input  logic task_sw,
  input  logic task_trap_bit,
  input  logic irq_req,
  output logic step_trap,
  output logic task_trap,
  output logic any_trap,
  output logic irq_first,
  output logic enter_handler
);
  always_comb begin
    step_trap     = (ev == EV_DONE) && tf_q;
    task_trap     = (ev == EV_DONE) && task_sw && task_trap_bit;
    any_trap      = step_trap || task_trap;
    irq_first     = any_trap && irq_req;
    enter_handler = any_trap || ((ev == EV_DONE) && irq_req);
  end
endmodule

// File: rtl/dbg_flag_regs.sv
module dbg_flag_regs
  import dbg_step_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  ev_e  ev,
  input  logic enter_handler,
  input  logic tf_wr,
  input  logic tf_wval,
  input  logic ss_load,
  input  logic task_sw,
  input  logic restore,
  input  logic restore_tf,
  input  logic restore_rf,
  output logic tf_q,
  output logic rf_q,
  output logic shadow_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tf_q     <= 1'b0;
      rf_q     <= 1'b0;
      shadow_q <= 1'b0;
    end else begin
      tf_q <= tf_after(ev, tf_q, tf_wr, tf_wval, enter_handler, restore, restore_tf);
      rf_q <= rf_after(ev, rf_q, task_sw, restore, restore_rf);
      if (ev != EV_NONE) shadow_q <= (ev == EV_DONE) && ss_load;
    end
  end

  assert_fault_sets_rf_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == EV_FAULT) |=> rf_q);
  assert_done_clears_rf_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == EV_DONE && !task_sw) |=> !rf_q);
  assert_task_keeps_rf_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == EV_DONE && task_sw) |=> $stable(rf_q));
endmodule

// File: rtl/dbg_step_seq.sv
module dbg_step_seq
  import dbg_step_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic i_insn_valid,
  input  logic i_insn_fault,
  input  logic i_bkpt_hit,
  input  logic i_tf_wr,
  input  logic i_tf_wval,
  input  logic i_ss_load,
  input  logic i_task_sw,
  input  logic i_task_trap_bit,
  input  logic i_irq_req,
  input  logic i_restore,
  input  logic i_restore_tf,
  input  logic i_restore_rf,
  output logic o_bkpt_fault,
  output logic o_dbg_trap,
  output logic o_irq_first,
  output logic o_st_step,
  output logic o_st_task,
  output logic o_tf,
  output logic o_rf
);
  ev_e  ev;
  logic bkpt_take, step_trap, task_trap, any_trap, irq_first, enter_handler;
  logic tf_q, rf_q, shadow_q;

  dbg_bkpt_gate u_gate (
    .insn_valid(i_insn_valid), .insn_fault(i_insn_fault), .bkpt_hit(i_bkpt_hit),
    .rf_q(rf_q), .shadow_q(shadow_q), .bkpt_take(bkpt_take), .ev(ev)
  );

  dbg_trap_eval u_eval (
    .ev(ev), .tf_q(tf_q), .task_sw(i_task_sw), .task_trap_bit(i_task_trap_bit),
    .irq_req(i_irq_req), .step_trap(step_trap), .task_trap(task_trap),
    .any_trap(any_trap), .irq_first(irq_first), .enter_handler(enter_handler)
  );

  dbg_flag_regs u_flags (
    .clk(clk), .rst_n(rst_n), .ev(ev), .enter_handler(enter_handler),
    .tf_wr(i_tf_wr), .tf_wval(i_tf_wval), .ss_load(i_ss_load), .task_sw(i_task_sw),
    .restore(i_restore), .restore_tf(i_restore_tf), .restore_rf(i_restore_rf),
    .tf_q(tf_q), .rf_q(rf_q), .shadow_q(shadow_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      o_bkpt_fault <= 1'b0;
      o_dbg_trap   <= 1'b0;
      o_irq_first  <= 1'b0;
      o_st_step    <= 1'b0;
      o_st_task    <= 1'b0;
    end else begin
      o_bkpt_fault <= bkpt_take;
      o_dbg_trap   <= any_trap;
      o_irq_first  <= irq_first;
      o_st_step    <= step_trap;
      o_st_task    <= task_trap;
    end
  end

  assign o_tf = tf_q;
  assign o_rf = rf_q;

  assert_step_on_old_tf_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (i_insn_valid && !i_insn_fault && !i_bkpt_hit && tf_q) |=> (o_dbg_trap && o_st_step));
  assert_no_trap_without_old_tf_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (i_insn_valid && !tf_q && !i_task_sw) |=> !o_dbg_trap);
  assert_handler_clears_tf_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (o_dbg_trap || o_bkpt_fault) |-> !o_tf);
  assert_irq_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    o_irq_first |-> (o_dbg_trap && !o_tf));
  assert_rf_blocks_bkpt_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (i_insn_valid && rf_q) |=> !o_bkpt_fault);
  assert_bkpt_no_trap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    o_bkpt_fault |-> !o_dbg_trap);
  assert_shadow_blocks_bkpt_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (i_insn_valid && shadow_q) |=> !o_bkpt_fault);
  assert_fault_drops_trap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (i_insn_valid && i_insn_fault) |=> !o_dbg_trap);
  assert_task_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
    o_st_task |-> o_dbg_trap);
  assert_status_onehot_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    o_dbg_trap |-> (o_st_step || o_st_task));
endmodule

// File: tb/dbg_step_seq_test.sv
module dbg_step_seq_test;
  logic clk = 1'b0;
  logic rst_n;
  logic [11:0] stim;
  logic o_bkpt_fault, o_dbg_trap, o_irq_first, o_st_step, o_st_task, o_tf, o_rf;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  // model state
  logic m_tf, m_rf, m_sh;

  always #2 clk = ~clk;

  dbg_step_seq uut (
    .clk(clk), .rst_n(rst_n),
    .i_insn_valid(stim[0]), .i_insn_fault(stim[1]), .i_bkpt_hit(stim[2]),
    .i_tf_wr(stim[3]), .i_tf_wval(stim[4]), .i_ss_load(stim[5]),
    .i_task_sw(stim[6]), .i_task_trap_bit(stim[7]), .i_irq_req(stim[8]),
    .i_restore(stim[9]), .i_restore_tf(stim[10]), .i_restore_rf(stim[11]),
    .o_bkpt_fault(o_bkpt_fault), .o_dbg_trap(o_dbg_trap), .o_irq_first(o_irq_first),
    .o_st_step(o_st_step), .o_st_task(o_st_task), .o_tf(o_tf), .o_rf(o_rf)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b (stim=%h)", req, act, exp, stim);
    end
  endtask

  // Apply one event, then compare all outputs with the model one cycle later.
  task automatic apply(input logic [11:0] s);
    logic v, flt, bk, wr, wv, ssl, tsw, tbit, irq, rs, rtf, rrf;
    logic is_bk, is_flt, is_done, e_step, e_task, e_tf, e_rf;
    {rrf, rtf, rs, irq, tbit, tsw, ssl, wv, wr, bk, flt, v} = s;
    is_bk   = v & bk & ~m_rf & ~m_sh;
    is_flt  = v & ~is_bk & flt;
    is_done = v & ~is_bk & ~flt;
    e_step  = is_done & m_tf;
    e_task  = is_done & tsw & tbit;
    if (!v)                              e_tf = rs ? rtf : m_tf;
    else if (!is_done || e_step || e_task || irq) e_tf = 1'b0;
    else                                 e_tf = wr ? wv : m_tf;
    if (!v)          e_rf = rs ? rrf : m_rf;
    else if (is_flt) e_rf = 1'b1;
    else if (is_bk)  e_rf = m_rf;
    else             e_rf = tsw & m_rf;
    stim = s;
    @(negedge clk);
    chk(m_sh ? "R6 bkpt" : "R5 bkpt", o_bkpt_fault, is_bk);
    chk(e_task ? "R9 trap" : "R1 trap", o_dbg_trap, e_step | e_task);
    chk("R1 st_step", o_st_step, e_step);
    chk("R9 st_task", o_st_task, e_task);
    chk("R4 irq_first", o_irq_first, (e_step | e_task) & irq);
    chk(v ? "R3 tf" : "R10 tf", o_tf, e_tf);
    chk(!v ? "R10 rf" : (is_flt ? "R7 rf" : "R8 rf"), o_rf, e_rf);
    m_tf = e_tf;
    m_rf = e_rf;
    if (v) m_sh = is_done & ssl;
  endtask

  // bit fields: 0 valid 1 fault 2 bkpt 3 tf_wr 4 tf_wval 5 ss_load 6 task_sw
  // 7 trap_bit 8 irq 9 restore 10 restore_tf 11 restore_rf
  initial begin
    stim = '0;
    rst_n = 1'b0;
    m_tf = 0; m_rf = 0; m_sh = 0;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 bkpt", o_bkpt_fault, 1'b0);
    chk("R11 trap", o_dbg_trap, 1'b0);
    chk("R11 tf", o_tf, 1'b0);
    chk("R11 rf", o_rf, 1'b0);
    rst_n = 1'b1;

    // R2: set TF -> no trap; next insn traps; insn clearing TF traps
    apply(12'h019);                  // write TF=1
    chk("R2 set no trap", o_dbg_trap, 1'b0);
    apply(12'h001);                  // plain completion, TF was 1
    chk("R2 next traps", o_dbg_trap, 1'b1);
    apply(12'h019);                  // set TF again (TF was 0 after trap)
    apply(12'h009);                  // write TF=0 while TF=1
    chk("R2 clear traps", o_dbg_trap, 1'b1);

    // R6: SS load then breakpoint hit is ignored; the one after is not
    apply(12'h021);
    apply(12'h005);
    chk("R6 shadow", o_bkpt_fault, 1'b0);
    apply(12'h005);
    chk("R6 window closed", o_bkpt_fault, 1'b1);

    // R5/R7: fault sets RF, restart over breakpoint is suppressed, then RF clears
    apply(12'h003);
    chk("R7 rf set", o_rf, 1'b1);
    apply(12'h005);
    chk("R5 suppressed", o_bkpt_fault, 1'b0);
    chk("R8 rf cleared", o_rf, 1'b0);

    // R10: restore ignored while an instruction is present
    apply(12'hE01);
    chk("R10 ignored", o_rf, 1'b0);
    apply(12'hE00);
    chk("R10 loaded", o_rf, 1'b1);

    // near-exhaustive sweep in scrambled order
    for (int i = 0; i < 4096; i++) apply(12'((i * 2477 + 91) % 4096));

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule